// File: doc/BRIEF.md
# Load/Store Multiple Register Sequencer

This block moves a group of registers between a register file port and a memory port, one register per clock cycle. A request gives a start address, a 5-bit list code, a direction (load or store) and a width select (32-bit or 64-bit words). The list code does not mark registers one by one. Its low four bits give the length of a prefix taken from a fixed nine-entry register table. Its top bit adds a final transfer of the link register.

On a load, the block reads memory and writes the register file in the same cycle. On a store, it reads the register file and writes memory. The address steps by the word size after each transfer. A single-cycle completion pulse follows the last transfer. Exceptions, interlocks and the register file storage itself are left to the surrounding core.

Top module: `lsm_seq`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `done`, `memEn`, `memWrEn` and `rfWrEn` are all low.
- R2: A request with list-code count c = `listCode[3:0]` in 1..9 transfers the first c entries of the table 16, 17, 18, 19, 20, 21, 22, 23, 30, in that order. It makes one transfer per cycle, and the first transfer is in the cycle after the one in which `start` is sampled.
- R3: A count of 0 or of 10..15 makes no table transfers.
- R4: When `listCode[4]` is 1, one more transfer of register 31 follows any table transfers, at the next address in the sequence. When the count is out of range, that transfer uses the start address unchanged.
- R5: The first transfer uses `startAddr`. Each later transfer adds 4 to the address when `isWide` = 0 and 8 when `isWide` = 1. `memWide` carries the width of the request in every transfer.
- R6: On a load (`isStore` = 0), `rfWrData` equals `memRData` for 64-bit words. For 32-bit words it equals `memRData[31:0]` sign-extended to 64 bits.
- R7: On a store (`isStore` = 1), `memWrEn` is 1, `rfWrEn` is 0, and `memWData` equals `rfRdData` for 64-bit words, or `rfRdData[31:0]` with zero upper bits for 32-bit words. On a load, `rfWrEn` is 1 and `memWrEn` is 0.
- R8: `done` is high for one cycle, in the cycle after the last transfer. When no transfer is called for, it is high in the cycle after `start` is sampled. No transfer takes place in a `done` cycle.
- R9: `start` and every request input are ignored while `busy` is high. The sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| startAddr | input | AW | Address of the first transfer |
| listCode | input | 5 | [3:0] table count, [4] add link register |
| isStore | input | 1 | 1 = store-multiple, 0 = load-multiple |
| isWide | input | 1 | 1 = 64-bit words, 0 = 32-bit words |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rfIdx | output | 5 | Register number of the current transfer |
| rfWrEn | output | 1 | Register file write enable (loads) |
| rfWrData | output | XLEN | Register file write data |
| rfRdData | input | XLEN | Register file read data for rfIdx |
| memEn | output | 1 | Memory access this cycle |
| memWrEn | output | 1 | Memory write (stores) |
| memWide | output | 1 | Access is a 64-bit word |
| memAddr | output | AW | Memory address |
| memWData | output | XLEN | Memory write data |
| memRData | input | XLEN | Memory read data for memAddr, same cycle |

## Verification
The assertions assume two things. First, `memRData` and `rfRdData` answer combinationally in the cycle of the access. Second, the address never wraps within one sequence, since the step check uses plain addition. The stimulus keeps to both. Its memory and register models are pure functions of the current address or index, and every start address leaves room for ten steps below the top of the address space. Requests are issued only at idle boundaries, with one exception: a deliberate `start` pulse during a busy sequence, which carries changed request inputs to show they are ignored.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  localparam int TABLE_LEN = 9;
  localparam int REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] LINK_REG = 5'd31;
  localparam logic [REG_IDX_W-1:0] TABLE_BASE = 5'd16;
  localparam logic [REG_IDX_W-1:0] TABLE_LAST = 5'd30;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TABLE,
    ST_LINK
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       xfer;   // one transfer this cycle
    logic       load;   // capture a new request
    logic       link;   // current transfer is the link register
    logic [3:0] pos;    // table position of current transfer
  } seqStrobe_t;

  // Table position -> register number: 16..23, then 30
  function automatic logic [REG_IDX_W-1:0] tableReg(input logic [3:0] pos);
    if (pos < 4'd8) return TABLE_BASE + {1'b0, pos};
    return TABLE_LAST;
  endfunction

endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [4:0] listCode,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  seqState_t  state;
  logic [3:0] cntReg;
  logic [3:0] posReg;
  logic       linkReg;
  logic       tableOk;
  logic       accept;
  logic       lastTable;

  assign tableOk   = (listCode[3:0] != 4'd0) && (listCode[3:0] <= 4'(TABLE_LEN));
  assign accept    = start && (state == ST_IDLE);
  assign lastTable = (posReg == cntReg - 4'd1);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe.xfer = (state != ST_IDLE);
    strobe.load = accept;
    strobe.link = (state == ST_LINK);
    strobe.pos  = posReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cntReg  <= '0;
      posReg  <= '0;
      linkReg <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cntReg  <= listCode[3:0];
            linkReg <= listCode[4];
            posReg  <= '0;
            if (tableOk)          state <= ST_TABLE;
            else if (listCode[4]) state <= ST_LINK;
            else                  done  <= 1'b1;
          end
        end
        ST_TABLE: begin
          if (lastTable) begin
            if (linkReg) begin
              state <= ST_LINK;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end else begin
            posReg <= posReg + 4'd1;
          end
        end
        ST_LINK: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsm_datapath.sv
module lsm_datapath
  import lsm_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [AW-1:0]        startAddr,
  input  logic                 isStore,
  input  logic                 isWide,
  output logic [REG_IDX_W-1:0] rfIdx,
  output logic                 rfWrEn,
  output logic [XLEN-1:0]      rfWrData,
  input  logic [XLEN-1:0]      rfRdData,
  output logic                 memEn,
  output logic                 memWrEn,
  output logic                 memWide,
  output logic [AW-1:0]        memAddr,
  output logic [XLEN-1:0]      memWData,
  input  logic [XLEN-1:0]      memRData
);

  localparam int NARROW_W = 32;
  localparam int UPPER_W  = XLEN - NARROW_W;
  localparam logic [AW-1:0] STEP_NARROW = AW'(NARROW_W / 8);
  localparam logic [AW-1:0] STEP_WIDE   = AW'(XLEN / 8);

  logic [AW-1:0] addrReg;
  logic          storeReg;
  logic          wideReg;
  logic [AW-1:0] stride;

  assign stride = wideReg ? STEP_WIDE : STEP_NARROW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      storeReg <= 1'b0;
      wideReg  <= 1'b0;
    end else if (strobe.load) begin
      addrReg  <= startAddr;
      storeReg <= isStore;
      wideReg  <= isWide;
    end else if (strobe.xfer) begin
      addrReg  <= addrReg + stride;
    end
  end

  assign rfIdx   = strobe.link ? LINK_REG : tableReg(strobe.pos);
  assign memEn   = strobe.xfer;
  assign memWrEn = strobe.xfer && storeReg;
  assign rfWrEn  = strobe.xfer && !storeReg;
  assign memWide = wideReg;
  assign memAddr = addrReg;

  always_comb begin
    if (wideReg) begin
      rfWrData = memRData;
      memWData = rfRdData;
    end else begin
      rfWrData = {{UPPER_W{memRData[NARROW_W-1]}}, memRData[NARROW_W-1:0]};
      memWData = {{UPPER_W{1'b0}}, rfRdData[NARROW_W-1:0]};
    end
  end

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [AW-1:0]   startAddr,
  input  logic [4:0]      listCode,
  input  logic            isStore,
  input  logic            isWide,
  output logic            busy,
  output logic            done,
  output logic [4:0]      rfIdx,
  output logic            rfWrEn,
  output logic [XLEN-1:0] rfWrData,
  input  logic [XLEN-1:0] rfRdData,
  output logic            memEn,
  output logic            memWrEn,
  output logic            memWide,
  output logic [AW-1:0]   memAddr,
  output logic [XLEN-1:0] memWData,
  input  logic [XLEN-1:0] memRData
);

  seqStrobe_t strobe;

  lsm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .listCode (listCode),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  lsm_datapath #(.XLEN(XLEN), .AW(AW)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .isStore   (isStore),
    .isWide    (isWide),
    .rfIdx     (rfIdx),
    .rfWrEn    (rfWrEn),
    .rfWrData  (rfWrData),
    .rfRdData  (rfRdData),
    .memEn     (memEn),
    .memWrEn   (memWrEn),
    .memWide   (memWide),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .memRData  (memRData)
  );

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic [4:0]      rfIdx,
  input logic            rfWrEn,
  input logic [XLEN-1:0] rfWrData,
  input logic            memEn,
  input logic            memWrEn,
  input logic            memWide,
  input logic [AW-1:0]   memAddr
);

  localparam logic [AW-1:0] STEP_N = AW'(4);
  localparam logic [AW-1:0] STEP_W = AW'(XLEN / 8);

  // R7: a transfer is either a register write or a memory write, never both
  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWrEn && memWrEn));

  // R7: enables only during a transfer
  a_r7_en_in_xfer: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn || memWrEn) |-> memEn);

  // R5: consecutive transfers step by the word size
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |-> (memAddr == $past(memAddr) + (memWide ? STEP_W : STEP_N)));

  // R2: only table or link registers are addressed
  a_r2_legal_idx: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> ((rfIdx >= 5'd16 && rfIdx <= 5'd23) || rfIdx == 5'd30 || rfIdx == 5'd31));

  // R4: the link register transfer is always the last one
  a_r4_link_last: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && rfIdx == 5'd31) |=> !memEn);

  // R8: end of a transfer run is marked by done; no transfer in a done cycle
  a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memEn) |-> done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memEn && !busy));

  // R6: narrow loads are sign-extended
  a_r6_sext: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && !memWide) |-> (rfWrData[XLEN-1:32] == {(XLEN-32){rfWrData[31]}}));

endmodule

bind lsm_seq lsm_seq_chk #(.XLEN(XLEN), .AW(AW)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .rfIdx    (rfIdx),
  .rfWrEn   (rfWrEn),
  .rfWrData (rfWrData),
  .memEn    (memEn),
  .memWrEn  (memWrEn),
  .memWide  (memWide),
  .memAddr  (memAddr)
);

// File: tb/test_lsm_seq.sv
`timescale 1ns/1ps
module test_lsm_seq;

  localparam int XLEN = 64;
  localparam int AW   = 32;
  localparam int NVEC = 10;

  // {listCode[4:0], isStore, isWide, startAddr[31:0]}
  localparam logic [38:0] VECS [NVEC] = '{
    {5'h03, 1'b0, 1'b0, 32'h0000_1000},
    {5'h09, 1'b1, 1'b0, 32'h8000_0040},
    {5'h19, 1'b0, 1'b1, 32'h0000_2008},
    {5'h10, 1'b0, 1'b0, 32'h0000_3000},
    {5'h1C, 1'b1, 1'b1, 32'h0000_4000},
    {5'h00, 1'b0, 1'b0, 32'h0000_5000},
    {5'h0F, 1'b1, 1'b0, 32'h0000_6000},
    {5'h01, 1'b1, 1'b1, 32'h0000_7010},
    {5'h15, 1'b0, 1'b0, 32'h8000_0008},
    {5'h0A, 1'b0, 1'b1, 32'h0000_9000}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [AW-1:0]   startAddr = '0;
  logic [4:0]      listCode = '0;
  logic            isStore = 1'b0;
  logic            isWide = 1'b0;
  logic            busy, done, rfWrEn, memEn, memWrEn, memWide;
  logic [4:0]      rfIdx;
  logic [XLEN-1:0] rfWrData, rfRdData, memWData, memRData;
  logic [AW-1:0]   memAddr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  function automatic logic [XLEN-1:0] memModel(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_0F0F, a[3], a[30:0] ^ 31'h0000_1234};
  endfunction

  function automatic logic [XLEN-1:0] rfModel(input logic [4:0] i);
    return {27'h5C0_0000, i, 19'h4_0000, i, 8'h00};
  endfunction

  assign memRData = memModel(memAddr);
  assign rfRdData = rfModel(rfIdx);

  lsm_seq #(.XLEN(XLEN), .AW(AW)) i_lsm_seq (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .listCode(listCode), .isStore(isStore), .isWide(isWide),
    .busy(busy), .done(done), .rfIdx(rfIdx), .rfWrEn(rfWrEn),
    .rfWrData(rfWrData), .rfRdData(rfRdData), .memEn(memEn),
    .memWrEn(memWrEn), .memWide(memWide), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData)
  );

  task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Run one request; optionally poke start with altered inputs while busy (R9)
  task automatic runOp(input logic [4:0] lc, input bit st, input bit wd,
                       input logic [AW-1:0] a, input bit poke);
    logic [4:0]    eIdx [10];
    int            n = 0;
    logic [AW-1:0] stp;
    logic [AW-1:0] ea;
    logic [XLEN-1:0] m, r;
    stp = wd ? 32'd8 : 32'd4;
    if (lc[3:0] >= 4'd1 && lc[3:0] <= 4'd9)
      for (int i = 0; i < int'(lc[3:0]); i++) begin
        eIdx[n] = (i < 8) ? 5'(16 + i) : 5'd30;   // R2 table order
        n++;
      end
    if (lc[4]) begin eIdx[n] = 5'd31; n++; end     // R4 link last
    @(negedge clk);
    start = 1'b1; listCode = lc; isStore = st; isWide = wd; startAddr = a;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      ea = a + stp * AW'(k);
      check(memEn == 1'b1 && done == 1'b0, "R2", {63'b0, memEn}, 64'd1);
      check(rfIdx == eIdx[k], "R2", {59'b0, rfIdx}, {59'b0, eIdx[k]});
      check(memAddr == ea, "R5", {32'b0, memAddr}, {32'b0, ea});
      check(memWide == wd, "R5", {63'b0, memWide}, {63'b0, wd});
      check(memWrEn == st && rfWrEn == !st, "R7", {62'b0, memWrEn, rfWrEn}, {62'b0, st, !st});
      if (st) begin
        r = rfModel(eIdx[k]);
        if (!wd) r = {32'b0, r[31:0]};
        check(memWData == r, "R7", memWData, r);
      end else begin
        m = memModel(ea);
        if (!wd) m = {{32{m[31]}}, m[31:0]};
        check(rfWrData == m, "R6", rfWrData, m);
      end
      if (poke && k == 0) begin
        start = 1'b1; listCode = 5'h1F; isStore = !st; isWide = !wd; startAddr = 32'h0000_0F00;
      end
      @(negedge clk);
      start = 1'b0;
    end
    // R8 done one cycle after the last transfer (or after start when empty)
    check(done == 1'b1 && memEn == 1'b0 && busy == 1'b0, "R8",
          {61'b0, done, memEn, busy}, 64'd4);
    if (n == 0)
      check(memEn == 1'b0, "R3", {63'b0, memEn}, 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8", {63'b0, done}, 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !memEn && !memWrEn && !rfWrEn, "R1",
          {59'b0, busy, done, memEn, memWrEn, rfWrEn}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !memEn && !memWrEn && !rfWrEn, "R1",
          {59'b0, busy, done, memEn, memWrEn, rfWrEn}, 64'd0);

    for (int v = 0; v < NVEC; v++)
      runOp(VECS[v][38:34], VECS[v][33], VECS[v][32], VECS[v][31:0], 1'b0);

    // R3 / R4: out-of-range count with link uses start address unchanged
    runOp(5'h1F, 1'b1, 1'b0, 32'h0000_A004, 1'b0);
    // R2: full table, then back-to-back request
    runOp(5'h19, 1'b1, 1'b0, 32'h0000_B000, 1'b0);
    runOp(5'h02, 1'b0, 1'b1, 32'h0000_C000, 1'b0);
    // R9: start with altered inputs during busy is ignored
    runOp(5'h04, 1'b0, 1'b0, 32'h0000_D000, 1'b1);
    runOp(5'h11, 1'b1, 1'b1, 32'h0000_E000, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule